// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

This block is a bank of independent pulse-width timers behind a small word-addressed register bus. Each channel owns a 16-bit up-counter, a duty compare value, a period compare value and a three-bit control word. The counter advances only when two things are true: its channel has been started through a shared start/stop register pair, and its per-channel clock-enable input is high. The channel drives one output pin. That pin idles at a programmable resting level, takes the opposite level once the count reaches the duty value, and goes back to the resting level when the counter wraps after the period value.

All counters are started by writing ones to a start register and stopped by writing ones to a stop register, so software never needs a read-modify-write. A read-only status word shows which counters are running. Turning a channel's output off can take effect at once, or it can wait until the current period ends. The control word selects which.

Register map, in word addresses: 0 is start (write 1 to set), 1 is stop (write 1 to clear) and 2 is run status. Channel n occupies addresses 8+4n to 11+4n, in this order: control, count, duty, period. In the control word, bit 0 enables the output, bit 1 sets the resting level and bit 2 selects immediate shutdown. Reads of any other address return 0.

Top module: `pwmt_bank`

## Requirements
- R1: After reset every register reads 0, the run status is 0 and every pin is low.
- R2: A write to address 0 starts counter n for each bit n of the data that is 1. Bits that are 0 leave their counters unchanged, and the new state shows in the status word (address 2) after that clock edge.
- R3: A write to address 1 stops counter n for each bit n of the data that is 1. The counter keeps its value from the following clock edge onward, and bits that are 0 have no effect.
- R4: A running counter advances by one only on clock edges where its clock-enable input is high. With the input low it holds its value.
- R5: When an advancing counter equals the period value, it becomes 0 on that edge, so one period lasts period+1 counting steps.
- R6: With the output enabled, the pin is at the resting level (control bit 1) while the count is below the duty value. It is at the opposite level from count = duty through count = period.
- R7: When the duty value exceeds the period value, the pin stays at the resting level for the whole period.
- R8: Setting control bit 1 to 1 makes the resting level high, which inverts the whole waveform.
- R9: With immediate shutdown selected (control bit 2 = 1), clearing the output enable (bit 0) puts the pin at the resting level right after the write edge.
- R10: With immediate shutdown not selected, clearing the output enable lets the waveform continue until the counter wraps. From then on the pin stays at the resting level.
- R11: Writing the count register loads the written value, and that write takes priority over an advance on the same edge.
- R12: The status word ignores writes, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | CNT_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | CNT_W | Read data, combinational from the address |
| tick | input | NUM_CH | Per-channel counting clock enable |
| pwm_out | output | NUM_CH | Per-channel PWM pin |

## Verification
A counter that steps when it should not, or misses its wrap, shows up first in the count register readback on the very next cycle. It then shows as a wrong number of high cycles per period on the pin. A wrong start or stop bit is visible in the status word one edge after the write. A stuck drain flag shows up as a pin that either keeps toggling after the wrap it should have stopped at, or drops at the moment output enable clears when immediate shutdown is not selected. The bench counts high cycles over whole periods for several duty/period/level combinations, including duty above period, duty 0 and period 0.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int EN_SET_ADDR  = 0;
  localparam int EN_CLR_ADDR  = 1;
  localparam int EN_STAT_ADDR = 2;
  localparam int CH_BASE_ADDR = 8;
  localparam int CH_STRIDE    = 4;

  localparam int CTRL_W = 3;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_DUTY   = 2'd2,
    REG_PERIOD = 2'd3
  } chan_reg_e;

  typedef struct packed {
    logic abrupt;    // bit 2
    logic init_lvl;  // bit 1
    logic out_en;    // bit 0
  } chan_ctrl_t;

endpackage

// File: rtl/pwmt_decode.sv
module pwmt_decode
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              set_we,
  output logic              clr_we,
  output logic              stat_hit,
  output logic              ch_hit,
  output logic [IDX_W-1:0]  ch_idx,
  output chan_reg_e         reg_off,
  output logic [NUM_CH-1:0] ch_we
);

  localparam int CH_END = CH_BASE_ADDR + CH_STRIDE * NUM_CH;

  logic [ADDR_W-1:0] rel;

  assign set_we   = we && (addr == ADDR_W'(EN_SET_ADDR));
  assign clr_we   = we && (addr == ADDR_W'(EN_CLR_ADDR));
  assign stat_hit = (addr == ADDR_W'(EN_STAT_ADDR));
  assign ch_hit   = (int'(addr) >= CH_BASE_ADDR) && (int'(addr) < CH_END);
  assign rel      = addr - ADDR_W'(CH_BASE_ADDR);
  assign ch_idx   = IDX_W'(rel >> 2);
  assign reg_off  = chan_reg_e'(rel[1:0]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_we
    assign ch_we[i] = we && ch_hit && (ch_idx == IDX_W'(i));
  end

endmodule

// File: rtl/pwmt_enable.sv
module pwmt_enable #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] run_q
);

  logic [NUM_CH-1:0] set_m, clr_m;

  assign set_m = set_we ? mask : '0;
  assign clr_m = clr_we ? mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= (run_q | set_m) & ~clr_m;
  end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             wr_en,
  input  chan_reg_e        wr_off,
  input  logic [CNT_W-1:0] wr_data,
  output chan_ctrl_t       ctrl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] duty_q,
  output logic [CNT_W-1:0] period_q,
  output logic             adv,
  output logic             wrap,
  output logic             cnt_wr,
  output logic             pin
);

  // Count after one step: wrap to zero on reaching the period value.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    return (c == p) ? '0 : c + 1'b1;
  endfunction

  // Past the duty point inside a period; a duty above period never matches.
  function automatic logic past_duty(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] d,
                                     input logic [CNT_W-1:0] p);
    return (d <= p) && (c >= d);
  endfunction

  logic drain_q;
  logic active;

  assign adv    = run && tick;
  assign wrap   = adv && (cnt_q == period_q);
  assign cnt_wr = wr_en && (wr_off == REG_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      duty_q   <= '0;
      period_q <= '0;
    end else if (wr_en) begin
      case (wr_off)
        REG_CTRL:   ctrl_q   <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
        REG_DUTY:   duty_q   <= wr_data;
        REG_PERIOD: period_q <= wr_data;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= wr_data;
    else if (adv)    cnt_q <= step_count(cnt_q, period_q);
  end

  // Set while the output is or was enabled within the current period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drain_q <= 1'b0;
    else        drain_q <= (ctrl_q.out_en | drain_q) & ~wrap;
  end

  assign active = ctrl_q.out_en | (drain_q & ~ctrl_q.abrupt);
  assign pin    = ctrl_q.init_lvl ^ (active & past_duty(cnt_q, duty_q, period_q));

endmodule

// File: rtl/pwmt_bank.sv
module pwmt_bank
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] tick,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic                          set_we, clr_we, stat_hit, ch_hit;
  logic [IDX_W-1:0]              ch_idx;
  chan_reg_e                     reg_off;
  logic [NUM_CH-1:0]             ch_we;
  logic [NUM_CH-1:0]             run_q;
  logic [NUM_CH-1:0]             adv_ev, wrap_ev, cnt_wr_ev;
  logic [NUM_CH-1:0]             oe_v, init_v, abrupt_v;
  chan_ctrl_t [NUM_CH-1:0]       ctrl_a;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a, duty_a, period_a;

  pwmt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
    .addr(bus_addr), .we(bus_we), .set_we(set_we), .clr_we(clr_we),
    .stat_hit(stat_hit), .ch_hit(ch_hit), .ch_idx(ch_idx),
    .reg_off(reg_off), .ch_we(ch_we)
  );

  pwmt_enable #(.NUM_CH(NUM_CH)) en_i (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .mask(bus_wdata[NUM_CH-1:0]), .run_q(run_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwmt_channel #(.CNT_W(CNT_W)) ch_i (
      .clk(clk), .rst_n(rst_n), .tick(tick[i]), .run(run_q[i]),
      .wr_en(ch_we[i]), .wr_off(reg_off), .wr_data(bus_wdata),
      .ctrl_q(ctrl_a[i]), .cnt_q(cnt_a[i]), .duty_q(duty_a[i]),
      .period_q(period_a[i]), .adv(adv_ev[i]), .wrap(wrap_ev[i]),
      .cnt_wr(cnt_wr_ev[i]), .pin(pwm_out[i])
    );
    assign oe_v[i]     = ctrl_a[i].out_en;
    assign init_v[i]   = ctrl_a[i].init_lvl;
    assign abrupt_v[i] = ctrl_a[i].abrupt;
  end

  always_comb begin
    bus_rdata = '0;
    if (stat_hit) begin
      bus_rdata = CNT_W'(run_q);
    end else if (ch_hit) begin
      case (reg_off)
        REG_CTRL:   bus_rdata = CNT_W'(ctrl_a[ch_idx]);
        REG_COUNT:  bus_rdata = cnt_a[ch_idx];
        REG_DUTY:   bus_rdata = duty_a[ch_idx];
        REG_PERIOD: bus_rdata = period_a[ch_idx];
        default:    bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/pwmt_bank_chk.sv
module pwmt_bank_chk
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [CNT_W-1:0]             bus_wdata,
  input logic                         bus_we,
  input logic [NUM_CH-1:0]            run_q,
  input logic [NUM_CH-1:0]            adv_ev,
  input logic [NUM_CH-1:0]            cnt_wr_ev,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_a,
  input logic [NUM_CH-1:0][CNT_W-1:0] duty_a,
  input logic [NUM_CH-1:0][CNT_W-1:0] period_a,
  input logic [NUM_CH-1:0]            oe_v,
  input logic [NUM_CH-1:0]            init_v,
  input logic [NUM_CH-1:0]            abrupt_v,
  input logic [NUM_CH-1:0]            pwm_out
);

  logic set_w, clr_w;
  assign set_w = bus_we && (bus_addr == ADDR_W'(EN_SET_ADDR));
  assign clr_w = bus_we && (bus_addr == ADDR_W'(EN_CLR_ADDR));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_w && bus_wdata[g]) |=> run_q[g]);
    // R2
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_w && !bus_wdata[g]) |=> (run_q[g] == $past(run_q[g])));
    // R3
    stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && bus_wdata[g]) |=> !run_q[g]);
    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_ev[g] && !cnt_wr_ev[g]) |=> (cnt_a[g] == $past(cnt_a[g])));
    // R5
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_ev[g] && !cnt_wr_ev[g] && (cnt_a[g] == period_a[g])) |=> (cnt_a[g] == '0));
    // R7
    duty_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_a[g] > period_a[g]) |-> (pwm_out[g] == init_v[g]));
    // R9
    abrupt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_v[g] && abrupt_v[g]) |-> (pwm_out[g] == init_v[g]));
  end

endmodule

bind pwmt_bank pwmt_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .run_q(run_q), .adv_ev(adv_ev), .cnt_wr_ev(cnt_wr_ev),
  .cnt_a(cnt_a), .duty_a(duty_a), .period_a(period_a), .oe_v(oe_v),
  .init_v(init_v), .abrupt_v(abrupt_v), .pwm_out(pwm_out)
);

// File: tb/pwmt_bank_tb_top.sv
module pwmt_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int A_SET = 0, A_CLR = 1, A_STAT = 2;

  typedef struct packed {
    logic [15:0] duty;
    logic [15:0] period;
    logic        lvl;
    logic [15:0] exp_high;
  } vec_t;

  // High cycles over one period of period+1 steps
  localparam vec_t VECS [8] = '{
    '{16'd3,  16'd7,  1'b0, 16'd5},
    '{16'd0,  16'd4,  1'b0, 16'd5},
    '{16'd5,  16'd5,  1'b1, 16'd5},
    '{16'd9,  16'd6,  1'b0, 16'd0},
    '{16'd9,  16'd6,  1'b1, 16'd7},
    '{16'd2,  16'd10, 1'b1, 16'd2},
    '{16'd0,  16'd0,  1'b0, 16'd1},
    '{16'd6,  16'd6,  1'b0, 16'd1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [5:0]      bus_addr = '0;
  logic [15:0]     bus_wdata = '0;
  logic            bus_we = 1'b0;
  logic [15:0]     bus_rdata;
  logic [NCH-1:0]  tick = '1;
  logic [NCH-1:0]  pwm_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmt_bank #(.NUM_CH(NCH), .CNT_W(16), .ADDR_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .tick(tick), .pwm_out(pwm_out)
  );

  function automatic int ch_addr(input int ch, input int off);
    return 8 + 4 * ch + off;
  endfunction

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic wr(input int a, input logic [15:0] d);
    bus_addr  = 6'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_addr = 6'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    int nz, hi, bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    nz = 0;
    for (int c = 0; c < NCH; c++) begin
      for (int o = 0; o < 4; o++) begin
        rd(ch_addr(c, o), d);
        if (d != 0) nz++;
      end
    end
    chk("R1 regs", nz, 0);
    rd(A_STAT, d);
    chk("R1 status", d, 0);
    chk("R1 pins", pwm_out, 0);
    @(negedge clk);

    // R6 R7 R8: table walk, high cycles over one full period
    for (int v = 0; v < 8; v++) begin
      int c = v % NCH;
      wr(ch_addr(c, 0), 16'(1 | (VECS[v].lvl << 1)));
      wr(ch_addr(c, 1), 16'd0);
      wr(ch_addr(c, 2), VECS[v].duty);
      wr(ch_addr(c, 3), VECS[v].period);
      wr(A_SET, 16'(1 << c));
      hi = 0;
      for (int k = 0; k <= int'(VECS[v].period); k++) begin
        if (pwm_out[c]) hi++;
        @(negedge clk);
      end
      chk($sformatf("R6 R7 R8 vector %0d", v), hi, VECS[v].exp_high);
      wr(A_CLR, 16'(1 << c));
      wr(ch_addr(c, 0), 16'd0);
    end

    // R2 R3: start/stop masks
    wr(A_CLR, 16'hFFFF);
    wr(A_SET, 16'h0005);
    rd(A_STAT, d);
    chk("R2 start", d, 5);
    wr(A_SET, 16'h0002);
    rd(A_STAT, d);
    chk("R2 zeros keep", d, 7);
    wr(A_CLR, 16'h0004);
    rd(A_STAT, d);
    chk("R3 stop", d, 3);
    wr(A_CLR, 16'h0000);
    rd(A_STAT, d);
    chk("R3 zeros keep", d, 3);
    // R12: status ignores writes, unmapped reads 0
    wr(A_STAT, 16'h00FF);
    rd(A_STAT, d);
    chk("R12 status read-only", d, 3);
    rd(3, d);
    chk("R12 unmapped 3", d, 0);
    rd(63, d);
    chk("R12 unmapped 63", d, 0);
    wr(A_CLR, 16'hFFFF);

    // R4: clock-enable gating on channel 1
    tick[1] = 1'b0;
    wr(ch_addr(1, 1), 16'd0);
    wr(ch_addr(1, 3), 16'd100);
    wr(A_SET, 16'h0002);
    repeat (3) @(negedge clk);
    rd(ch_addr(1, 1), d);
    chk("R4 hold while tick low", d, 0);
    tick[1] = 1'b1;
    repeat (5) @(negedge clk);
    tick[1] = 1'b0;
    rd(ch_addr(1, 1), d);
    chk("R4 five ticks", d, 5);
    repeat (3) @(negedge clk);
    rd(ch_addr(1, 1), d);
    chk("R4 hold after ticks", d, 5);
    // R3: stop takes effect after the clear edge
    tick[1] = 1'b1;
    wr(A_CLR, 16'h0002);
    rd(ch_addr(1, 1), d);
    repeat (4) @(negedge clk);
    rd(ch_addr(1, 1), d2);
    chk("R3 frozen value", d, 6);
    chk("R3 frozen stable", d2, 6);

    // R5: wrap sequence, period 3 on channel 2
    wr(ch_addr(2, 1), 16'd0);
    wr(ch_addr(2, 3), 16'd3);
    wr(A_SET, 16'h0004);
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      rd(ch_addr(2, 1), d);
      if (d != 16'(k % 4)) bad++;
      @(negedge clk);
    end
    chk("R5 wrap sequence mismatches", bad, 0);
    // R11: count write overrides advance (would be 3)
    wr(ch_addr(2, 1), 16'd1);
    rd(ch_addr(2, 1), d);
    chk("R11 count load", d, 1);
    @(negedge clk);
    rd(ch_addr(2, 1), d);
    chk("R11 count after load", d, 2);
    wr(A_CLR, 16'h0004);

    // R9: immediate shutdown on channel 3
    wr(ch_addr(3, 2), 16'd0);
    wr(ch_addr(3, 3), 16'd20);
    wr(ch_addr(3, 1), 16'd0);
    wr(ch_addr(3, 0), 16'd5);
    wr(A_SET, 16'h0008);
    @(negedge clk);
    chk("R9 active before off", pwm_out[3], 1);
    wr(ch_addr(3, 0), 16'd4);
    chk("R9 resting right after off", pwm_out[3], 0);
    wr(A_CLR, 16'h0008);

    // R10: graceful shutdown on channel 4, period 9
    wr(ch_addr(4, 2), 16'd0);
    wr(ch_addr(4, 3), 16'd9);
    wr(ch_addr(4, 1), 16'd0);
    wr(ch_addr(4, 0), 16'd1);
    wr(A_SET, 16'h0010);
    repeat (3) @(negedge clk);
    wr(ch_addr(4, 0), 16'd0);
    hi = 0;
    for (int k = 0; k < 6; k++) begin
      if (pwm_out[4]) hi++;
      @(negedge clk);
    end
    chk("R10 runs to period end", hi, 6);
    hi = 0;
    for (int k = 0; k < 12; k++) begin
      if (pwm_out[4]) hi++;
      @(negedge clk);
    end
    chk("R10 resting after wrap", hi, 0);

    report();
    $finish;
  end

endmodule